// File: doc/BRIEF.md
# Free-Running Sync and Test Pattern Generator

This block owns the horizontal and vertical sync output pins of a display controller. In pass-through mode it forwards conditioned sync inputs to the outputs, and each output has its own polarity control. When composite sync is selected, the block learns the line period from the incoming horizontal edges. If an expected horizontal pulse does not arrive, it places a pulse of fixed width on the output.

In free-run mode the block ignores the inputs and generates sync from one of five built-in timing sets. Each set fixes the line period, the sync width, the front porch and the back porch in microseconds, and the frame length, sync width and porches in lines. While free-run is active, a push-pull test pattern pin can be enabled. It draws either a full white field or a one-pixel white border inside the active video area. It is driven low during sync and porch regions.

Configuration comes through two small write-only registers. Setting the clock rate parameter scales every microsecond figure into clock cycles.

Top module: `fsg_top`

## Requirements
- R1: After reset hs_out, vs_out, pat_out and pat_oe are 0. Register 0 resets to all zeros. Register 1 resets to pattern-disable 1 and select 0.
- R2: Register 0 (cfg_addr=0) holds these fields: bit0 inverts hs_out, bit1 inverts vs_out, bit2 enables free-run, bit3 selects composite-sync handling, and bits 6:4 select the timing set. In pass-through mode, hs_out and vs_out equal the input XOR the matching inversion bit, one clock after the input.
- R3: With composite handling on, the line period P is the spacing in cycles between the last two rising edges of hs_in. If P + floor(P/4) cycles pass after a rising edge with no new edge, an inserted pulse of 2 µs (2·CYC_PER_US cycles) starts on the next cycle. The timeout then restarts from the insertion.
- R4: No pulse is inserted while composite handling is off, or before two rising edges have been seen since it was turned on.
- R5: Free-run uses these timing sets, given as line µs/hsync µs/back porch µs/front porch µs and frame lines/vsync lines/back porch lines/front porch lines. Set 0 is 64/4/8/4 and 262/3/16/3. Set 1 is 32/4/2/1 and 525/2/33/10. Set 2 is 26/3/2/1 and 628/4/23/1. Set 3 is 21/2/2/1 and 806/6/29/3. Set 4 is 16/1/2/1 and 1066/3/38/1. Select values 5 to 7 map to set 4. Sync is active at the start of each line and frame.
- R6: A change of the set select while free-run is running takes effect only at the next frame start. When free-run starts, it uses the current select.
- R7: pat_oe is 1 exactly when free-run is active and the pattern-disable bit is 0. While pat_oe is 0, pat_out is 0.
- R8: Register 1 (cfg_addr=1, bit0 active-low pattern enable, bit1 pattern type) ignores writes while the free-run bit is 0.
- R9: Pattern type 0 (white field) drives pat_out high on every pixel of the active region and low during sync and porches. In set 1 this gives 25×480 = 12000 high cycles per frame.
- R10: Pattern type 1 (border) drives pat_out high only on the first and last active line and the first and last active column. In set 1 this gives 1006 high cycles per frame.
- R11: The polarity bits also apply in free-run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select |
| cfg_wdata | input | 7 | Register write data |
| hs_in | input | 1 | Conditioned horizontal or composite sync input, active high |
| vs_in | input | 1 | Conditioned vertical sync input, active high |
| hs_out | output | 1 | Horizontal sync output |
| vs_out | output | 1 | Vertical sync output |
| pat_out | output | 1 | Test pattern video |
| pat_oe | output | 1 | Push-pull drive enable for the pattern pin |

## Verification
A register write takes effect on the clock edge after the strobe. From then on, every output is registered once.

- Pass-through results therefore appear one clock after the input.
- An inserted pulse is first visible P + floor(P/4) + 1 clock edges after the edge that registered the last real rising edge.
- Free-run starts two clocks after the enabling write.

The bench samples on falling edges and counts those edges from the stimulus to hit exactly those cycles. Free-run periods, widths and per-frame pattern counts are measured between output edges, so the fixed pipeline delay cancels out.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam int MAX_HPER_US = 64;
  localparam int VLW         = 11;
  localparam int NUM_SETS    = 5;

  typedef struct packed {
    logic [6:0]     hper;
    logic [6:0]     hsw;
    logic [6:0]     hbp;
    logic [6:0]     hfp;
    logic [VLW-1:0] vper;
    logic [VLW-1:0] vsw;
    logic [VLW-1:0] vbp;
    logic [VLW-1:0] vfp;
  } tset_t;

  function automatic tset_t mk_set(input int hp, input int hs, input int hb, input int hf,
                                   input int vp, input int vs, input int vb, input int vf);
    tset_t t;
    t.hper = 7'(hp);
    t.hsw  = 7'(hs);
    t.hbp  = 7'(hb);
    t.hfp  = 7'(hf);
    t.vper = VLW'(vp);
    t.vsw  = VLW'(vs);
    t.vbp  = VLW'(vb);
    t.vfp  = VLW'(vf);
    return t;
  endfunction

  // Timing sets: horizontal figures in microseconds, vertical in lines.
  function automatic tset_t tset_of(input logic [2:0] idx);
    case (idx)
      3'd0:    return mk_set(64, 4, 8, 4,  262, 3, 16, 3);
      3'd1:    return mk_set(32, 4, 2, 1,  525, 2, 33, 10);
      3'd2:    return mk_set(26, 3, 2, 1,  628, 4, 23, 1);
      3'd3:    return mk_set(21, 2, 2, 1,  806, 6, 29, 3);
      default: return mk_set(16, 1, 2, 1, 1066, 3, 38, 1);
    endcase
  endfunction

  // Out-of-range selects fall back to the last set.
  function automatic logic [2:0] clamp_sel(input logic [2:0] s);
    return (int'(s) >= NUM_SETS) ? 3'(NUM_SETS - 1) : s;
  endfunction

endpackage

// File: rtl/fsg_regs.sv
module fsg_regs
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       addr,
  input  logic [6:0] wdata,
  output logic       hs_inv,
  output logic       vs_inv,
  output logic       fr_en,
  output logic       csync_en,
  output logic [2:0] sel,
  output logic       pat_en_n,
  output logic       pat_sel
);

  logic [2:0] sel_raw;
  logic       pat_wr_blocked;

  assign pat_wr_blocked = we && addr && !fr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_inv   <= 1'b0;
      vs_inv   <= 1'b0;
      fr_en    <= 1'b0;
      csync_en <= 1'b0;
      sel_raw  <= 3'd0;
      pat_en_n <= 1'b1;
      pat_sel  <= 1'b0;
    end else if (we) begin
      if (!addr) begin
        hs_inv   <= wdata[0];
        vs_inv   <= wdata[1];
        fr_en    <= wdata[2];
        csync_en <= wdata[3];
        sel_raw  <= wdata[6:4];
      end else if (fr_en) begin
        pat_en_n <= wdata[0];
        pat_sel  <= wdata[1];
      end
    end
  end

  assign sel = clamp_sel(sel_raw);

  assert_pat_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pat_wr_blocked |=> ($stable(pat_en_n) && $stable(pat_sel)));

endmodule

// File: rtl/fsg_csync.sv
module fsg_csync #(
  parameter int PER_W = 16,
  parameter int INS_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_in,
  input  logic en,
  output logic ins_act,
  output logic rise,
  output logic ins_fire
);

  localparam int IW = $clog2(INS_W + 1);
  localparam logic [PER_W-1:0] ONE_P  = 1;
  localparam logic [PER_W:0]   ONE_PW = 1;
  localparam logic [IW-1:0]    ONE_I  = 1;
  localparam logic [IW-1:0]    INS_LD = IW'(INS_W);

  logic             hs_prev;
  logic             edge_seen;
  logic             per_valid;
  logic [PER_W-1:0] per;
  logic [PER_W-1:0] since;
  logic [IW-1:0]    ins_cnt;

  // Timeout window: the measured period plus a quarter of it.
  function automatic logic [PER_W:0] limit_of(input logic [PER_W-1:0] p);
    return {1'b0, p} + {3'b000, p[PER_W-1:2]};
  endfunction

  assign rise     = hs_in && !hs_prev;
  assign ins_fire = en && per_valid && !rise && (({1'b0, since} + ONE_PW) == limit_of(per));
  assign ins_act  = (ins_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev   <= 1'b0;
      edge_seen <= 1'b0;
      per_valid <= 1'b0;
      per       <= '0;
      since     <= '0;
      ins_cnt   <= '0;
    end else begin
      hs_prev <= hs_in;
      if (ins_act) ins_cnt <= ins_cnt - ONE_I;
      if (!en) begin
        edge_seen <= 1'b0;
        per_valid <= 1'b0;
        since     <= '0;
        ins_cnt   <= '0;
      end else if (rise) begin
        since     <= '0;
        edge_seen <= 1'b1;
        if (edge_seen) begin
          per       <= since + ONE_P;
          per_valid <= 1'b1;
        end
      end else if (ins_fire) begin
        since   <= '0;
        ins_cnt <= INS_LD;
      end else if (since != '1) begin
        since <= since + ONE_P;
      end
    end
  end

  assert_ins_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_act |-> per_valid);

  assert_ins_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> (ins_act && since == '0));

endmodule

// File: rtl/fsg_timing.sv
module fsg_timing
  import fsg_pkg::*;
#(
  parameter int CYC_PER_US = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fr_en,
  input  logic [2:0] sel,
  input  logic       pat_sel,
  output logic       fr_active,
  output logic       hs_gen,
  output logic       vs_gen,
  output logic       pat_gen,
  output logic       frame_wrap
);

  localparam int HW = $clog2(MAX_HPER_US * CYC_PER_US + 1);
  localparam logic [HW-1:0]  ONE_H = 1;
  localparam logic [VLW-1:0] ONE_V = 1;

  function automatic logic [HW-1:0] us2cyc(input logic [6:0] us);
    return HW'(int'(us) * CYC_PER_US);
  endfunction

  logic           run_q;
  logic [2:0]     act_set;
  logic [HW-1:0]  h_cnt;
  logic [VLW-1:0] v_cnt;
  tset_t          ts;
  logic [HW-1:0]  hper, hsw, hvid_lo, hvid_hi;
  logic [VLW-1:0] vvid_lo, vvid_hi;
  logic           line_end, h_vid, v_vid, edge_px;

  assign ts      = tset_of(act_set);
  assign hper    = us2cyc(ts.hper);
  assign hsw     = us2cyc(ts.hsw);
  assign hvid_lo = hsw + us2cyc(ts.hbp);
  assign hvid_hi = hper - us2cyc(ts.hfp);
  assign vvid_lo = ts.vsw + ts.vbp;
  assign vvid_hi = ts.vper - ts.vfp;

  assign line_end   = (h_cnt == hper - ONE_H);
  assign frame_wrap = line_end && (v_cnt == ts.vper - ONE_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      act_set <= 3'd0;
      h_cnt   <= '0;
      v_cnt   <= '0;
    end else begin
      run_q <= fr_en;
      if (!run_q) begin
        act_set <= sel;
        h_cnt   <= '0;
        v_cnt   <= '0;
      end else if (line_end) begin
        h_cnt <= '0;
        if (frame_wrap) begin
          v_cnt   <= '0;
          act_set <= sel;
        end else begin
          v_cnt <= v_cnt + ONE_V;
        end
      end else begin
        h_cnt <= h_cnt + ONE_H;
      end
    end
  end

  assign fr_active = run_q;
  assign hs_gen    = (h_cnt < hsw);
  assign vs_gen    = (v_cnt < ts.vsw);
  assign h_vid     = (h_cnt >= hvid_lo) && (h_cnt < hvid_hi);
  assign v_vid     = (v_cnt >= vvid_lo) && (v_cnt < vvid_hi);
  assign edge_px   = (h_cnt == hvid_lo) || (h_cnt == hvid_hi - ONE_H) ||
                     (v_cnt == vvid_lo) || (v_cnt == vvid_hi - ONE_V);
  assign pat_gen   = h_vid && v_vid && (!pat_sel || edge_px);

  assert_hcnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (h_cnt < hper && v_cnt < ts.vper));

  assert_set_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !frame_wrap) |=> (!run_q || $stable(act_set)));

  assert_pat_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pat_gen |-> (!hs_gen && !vs_gen));

endmodule

// File: rtl/fsg_top.sv
module fsg_top #(
  parameter int CYC_PER_US = 1,
  parameter int PER_W      = 16,
  parameter int INS_US     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_addr,
  input  logic [6:0] cfg_wdata,
  input  logic       hs_in,
  input  logic       vs_in,
  output logic       hs_out,
  output logic       vs_out,
  output logic       pat_out,
  output logic       pat_oe
);

  localparam int INS_W = INS_US * CYC_PER_US;

  logic       hs_inv, vs_inv, fr_en, csync_en, pat_en_n, pat_sel;
  logic [2:0] sel;
  logic       fr_active, hs_gen, vs_gen, pat_gen, frame_wrap;
  logic       ins_act, hs_rise, ins_fire;
  logic       hs_src, vs_src, pat_on;

  fsg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .hs_inv   (hs_inv),
    .vs_inv   (vs_inv),
    .fr_en    (fr_en),
    .csync_en (csync_en),
    .sel      (sel),
    .pat_en_n (pat_en_n),
    .pat_sel  (pat_sel)
  );

  fsg_csync #(.PER_W(PER_W), .INS_W(INS_W)) u_csync (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_in    (hs_in),
    .en       (csync_en),
    .ins_act  (ins_act),
    .rise     (hs_rise),
    .ins_fire (ins_fire)
  );

  fsg_timing #(.CYC_PER_US(CYC_PER_US)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .fr_en      (fr_en),
    .sel        (sel),
    .pat_sel    (pat_sel),
    .fr_active  (fr_active),
    .hs_gen     (hs_gen),
    .vs_gen     (vs_gen),
    .pat_gen    (pat_gen),
    .frame_wrap (frame_wrap)
  );

  assign hs_src = fr_active ? hs_gen : (hs_in | ins_act);
  assign vs_src = fr_active ? vs_gen : vs_in;
  assign pat_on = fr_active && !pat_en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_out  <= 1'b0;
      vs_out  <= 1'b0;
      pat_out <= 1'b0;
      pat_oe  <= 1'b0;
    end else begin
      hs_out  <= hs_src ^ hs_inv;
      vs_out  <= vs_src ^ vs_inv;
      pat_oe  <= pat_on;
      pat_out <= pat_on && pat_gen;
    end
  end

  assert_pat_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pat_out |-> pat_oe);

endmodule

// File: tb/fsg_top_tb_top.sv
`timescale 1ns/1ps
module fsg_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       hs_in = 1'b0;
  logic       vs_in = 1'b0;
  logic       hs_out, vs_out, pat_out, pat_oe;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fsg_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hs_in(hs_in), .vs_in(vs_in),
    .hs_out(hs_out), .vs_out(vs_out), .pat_out(pat_out), .pat_oe(pat_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [6:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic pick(input int which);
    return (which == 0) ? hs_out : vs_out;
  endfunction

  task automatic wait_edge(input int which, input logic lvl, output int c);
    logic p, cur;
    bit done;
    p = pick(which);
    done = 0;
    while (!done) begin
      @(negedge clk);
      cur = pick(which);
      if (cur == lvl && p != lvl) done = 1;
      p = cur;
    end
    c = cyc;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      hs_in = 1'b1;
      repeat (3) @(negedge clk);
      hs_in = 1'b0;
      repeat (37) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 hs_out", hs_out, 0);
    chk("R1 vs_out", vs_out, 0);
    chk("R1 pat_out", pat_out, 0);
    chk("R1 pat_oe", pat_oe, 0);
  endtask

  task automatic t_passthru;
    hs_in = 1'b1;
    @(negedge clk);
    chk("R2 hs plain", hs_out, 1);
    hs_in = 1'b0;
    wr(1'b0, 7'h01);
    @(negedge clk);
    chk("R2 hs inverted", hs_out, 1);
    wr(1'b0, 7'h02);
    vs_in = 1'b1;
    @(negedge clk);
    chk("R2 vs inverted high in", vs_out, 0);
    vs_in = 1'b0;
    @(negedge clk);
    chk("R2 vs inverted low in", vs_out, 1);
    chk("R2 hs plain after rewrite", hs_out, 0);
    wr(1'b0, 7'h00);
    @(negedge clk);
  endtask

  task automatic t_insert;
    wr(1'b0, 7'h08);
    repeat (2) @(negedge clk);
    pulses(3);
    repeat (11) @(negedge clk);
    chk("R3 before insert", hs_out, 0);
    @(negedge clk);
    chk("R3 insert start", hs_out, 1);
    @(negedge clk);
    chk("R3 insert 2nd cycle", hs_out, 1);
    @(negedge clk);
    chk("R3 insert end", hs_out, 0);
    wr(1'b0, 7'h00);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_no_insert;
    int highs;
    wr(1'b0, 7'h08);
    pulses(1);
    highs = 0;
    repeat (100) begin @(negedge clk); highs += hs_out; end
    chk("R4 single edge no insert", highs, 0);
    wr(1'b0, 7'h00);
    pulses(3);
    highs = 0;
    repeat (100) begin @(negedge clk); highs += hs_out; end
    chk("R4 composite off no insert", highs, 0);
  endtask

  task automatic t_pat_ignore;
    int highs, oes;
    wr(1'b1, 7'h00);
    wr(1'b0, 7'h04);
    highs = 0; oes = 0;
    repeat (2000) begin @(negedge clk); highs += pat_out; oes += pat_oe; end
    chk("R8 pat_oe stays off", oes, 0);
    chk("R7 pat_out off", highs, 0);
  endtask

  task automatic t_freerun;
    int r1, f, r2, a, b, cv, ch, vf, cv2;
    wait_edge(0, 1'b1, r1);
    wait_edge(0, 1'b0, f);
    wait_edge(0, 1'b1, r2);
    chk("R5 set0 hsync width", f - r1, 4);
    chk("R5 set0 line period", r2 - r1, 64);
    wait_edge(1, 1'b1, cv);
    wait_edge(0, 1'b1, a);
    wr(1'b0, 7'h14);
    wait_edge(0, 1'b1, a);
    wait_edge(0, 1'b1, b);
    chk("R6 old set kept mid-frame", b - a, 64);
    wait_edge(1, 1'b1, cv);
    wait_edge(0, 1'b1, ch);
    chk("R6 new set after frame start", ch - cv, 32);
    wait_edge(1, 1'b0, vf);
    chk("R5 set1 vsync width", vf - cv, 64);
    wait_edge(1, 1'b1, cv2);
    chk("R5 set1 frame period", cv2 - cv, 16800);
  endtask

  task automatic count_frame(output int cnt, output int bad);
    int dummy;
    logic p;
    bit done;
    wait_edge(1, 1'b1, dummy);
    cnt = pat_out; bad = 0; p = 1'b1; done = 0;
    while (!done) begin
      @(negedge clk);
      if (vs_out && !p) done = 1;
      else begin
        cnt += pat_out;
        if (pat_out && (hs_out || vs_out)) bad++;
      end
      p = vs_out;
    end
  endtask

  task automatic t_patterns;
    int cnt, bad;
    wr(1'b1, 7'h00);
    @(negedge clk);
    chk("R7 pat_oe on", pat_oe, 1);
    count_frame(cnt, bad);
    chk("R9 white count", cnt, 12000);
    chk("R9 low in sync", bad, 0);
    wr(1'b1, 7'h02);
    count_frame(cnt, bad);
    chk("R10 border count", cnt, 1006);
    chk("R10 low in sync", bad, 0);
  endtask

  task automatic t_fr_polarity;
    int f1, r, f2;
    wr(1'b0, 7'h00);
    wr(1'b0, 7'h75);
    wait_edge(0, 1'b0, f1);
    wait_edge(0, 1'b1, r);
    wait_edge(0, 1'b0, f2);
    chk("R11 inverted sync width set4", r - f1, 1);
    chk("R5 select 7 maps to set4 period", f2 - f1, 16);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_insert();
    t_no_insert();
    t_pat_ignore();
    t_freerun();
    t_patterns();
    t_fr_polarity();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule